// File: doc/BRIEF.md
# Byte-to-Word Card Data Engine

This block sits between a byte-wide card data port and a host that moves 32-bit words. It holds a circular word store of parameterised depth (16 words by default). In the card-to-host direction it gathers incoming card bytes into words, least significant byte first, and queues them for the host. In the host-to-card direction it takes queued host words and sends them to the card one byte at a time, again least significant byte first. A byte down-counter, loaded from a programmed length when the data path is started, limits how many bytes cross the card port.

The host starts a transfer by strobing a control write with the start bit, the direction bit and the byte length. The engine moves at most one byte per clock and waits whenever the card side withholds its valid or ready signal, or when the store has no room or no data. A status vector reports the end of the byte count and the store's fill level. The level flags belong to the active direction, and the flags of the other direction read as zero. When the count has run out and the store is empty, the engine drops its enable by itself.

Top module: `bwe_engine`

## Requirements
- R1: The word store keeps host words in first-in first-out order and holds at most 16 words. A host push is taken only when the direction is host-to-card (ctrl_dir_rx = 0), the engine is enabled, the byte count is nonzero and the store is not full. Every other push is dropped without effect.
- R2: A host pop returns its word on host_rdata, with host_rvalid high, one clock after the request. A pop on an empty store, or a pop while the direction is host-to-card, returns zero and removes nothing.
- R3: A ctrl_wr with ctrl_enable = 1 loads byte_count from xfer_len (16 bits), raises data_en on the next clock and latches ctrl_dir_rx, where 1 means card to host. byte_count drops by one for every byte that crosses the card port. After reset data_en, byte_count and status are zero.
- R4: In the card-to-host direction, card_rx_ready is high only while the engine is enabled, the count is nonzero and the store is not full. Accepted bytes fill a word starting at bits 7:0, and the word is stored once its fourth byte arrives.
- R5: When the last counted byte arrives and the word is incomplete, the partial word is stored anyway, with zero in its unfilled upper bytes.
- R6: In the host-to-card direction, the engine takes the oldest word and presents its bytes on card_tx_byte from bits 7:0 upward, one byte per card_tx_valid/card_tx_ready handshake. Any bytes beyond the count are discarded.
- R7: When the count becomes zero, status bits 8 and 10 go high. They stay high until the next start. A start with length zero sets them at once.
- R8: data_en clears by itself once the count is zero and the store is empty with no word in flight. It stays high while any stored word remains.
- R9: While data_en is high, status reports active, empty (0 words), data-available (1 or more words), full (16 words), half-empty (8 or fewer) and half-full (8 or more). In the card-to-host direction these appear in bits 13, 19, 21, 17 and 15, with no half-empty flag. In the host-to-card direction they appear in bits 12, 18, 20, 16 and 14, with no half-full flag. All bits of the inactive group are zero, and both groups are zero while data_en is low.
- R10: While card_tx_valid is high and card_tx_ready is low, card_tx_valid stays high and card_tx_byte holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Strobe for the data-control fields |
| ctrl_enable | input | 1 | Start bit of the control write |
| ctrl_dir_rx | input | 1 | Direction: 1 card to host, 0 host to card |
| xfer_len | input | 16 | Byte length loaded on start |
| host_wr | input | 1 | Host word push request |
| host_wdata | input | 32 | Host word to push |
| host_rd | input | 1 | Host word pop request |
| host_rvalid | output | 1 | Pop answer valid (one clock after host_rd) |
| host_rdata | output | 32 | Popped word, or zero when rejected |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_byte | input | 8 | Byte from card |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| card_tx_valid | output | 1 | Engine offers a byte to card |
| card_tx_byte | output | 8 | Byte to card |
| card_tx_ready | input | 1 | Card accepts the byte |
| data_en | output | 1 | Data path enabled |
| byte_count | output | 16 | Bytes still to move |
| status | output | 22 | Completion and level flags |

## Verification
The hardest state to reach is a store filled to its limit while the engine already holds one word in its byte unpacker. In that state the host-to-card level reads 16 and one more push must vanish. The bench holds card_tx_ready low while it pushes 18 words, so the engine can only prefetch the first one. It then drains the card port and proves that the dropped word never appears and that data_en still falls. Random runs of both directions add card stalls and host pops that overlap engine pushes, and they vary the length modulo four so that partial trailing words occur.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
  localparam int STAT_W = 22;
  // completion flags
  localparam int B_DATA_END  = 8;
  localparam int B_BLOCK_END = 10;
  // level flag groups: transmit at even positions, receive one above
  localparam int B_ACT   = 12;
  localparam int B_HALF  = 14;
  localparam int B_FULL  = 16;
  localparam int B_EMPTY = 18;
  localparam int B_AVAIL = 20;

  typedef struct packed {
    logic active;
    logic half;
    logic full;
    logic empty;
    logic avail;
  } lvl_flags_t;
endpackage

// File: rtl/bwe_ring.sv
module bwe_ring #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign level   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (do_pop) rdata <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/bwe_rx_pack.sv
module bwe_rx_pack #(
  parameter int W    = 32,
  localparam int BPW = W / 8,
  localparam int IW  = $clog2(BPW)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         take,
  input  logic [7:0]   byte_i,
  input  logic         last,
  output logic         push,
  output logic [W-1:0] word
);
  logic [W-1:0]  acc_q;
  logic [IW-1:0] idx_q;

  assign word = acc_q | (W'(byte_i) << (8 * idx_q));
  assign push = take & ((idx_q == IW'(BPW-1)) | last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      if (push) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= word;
        idx_q <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/bwe_tx_unpack.sv
module bwe_tx_unpack #(
  parameter int W    = 32,
  localparam int BPW = W / 8,
  localparam int IW  = $clog2(BPW)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         can_fetch,
  input  logic [W-1:0] fetch_data,
  input  logic         send,
  input  logic         last,
  output logic         pop_req,
  output logic         have,
  output logic         busy,
  output logic [7:0]   byte_o
);
  logic [W-1:0] sh_q;
  logic [IW:0]  left_q;
  logic         pend_q;

  assign have    = (left_q != '0) & ~pend_q;
  assign busy    = pend_q;
  assign pop_req = can_fetch & (left_q == '0) & ~pend_q;
  assign byte_o  = sh_q[7:0];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q   <= '0;
      left_q <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      sh_q   <= fetch_data;
      left_q <= (IW+1)'(BPW);
      pend_q <= 1'b0;
    end else if (send) begin
      if (last) begin
        left_q <= '0;
      end else begin
        sh_q   <= sh_q >> 8;
        left_q <= left_q - (IW+1)'(1);
      end
    end else if (pop_req) begin
      pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/bwe_status.sv
module bwe_status
  import bwe_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              en,
  input  logic              dir_rx,
  input  logic              done,
  input  logic [AW:0]       level,
  output logic [STAT_W-1:0] stat
);
  lvl_flags_t f;

  always_comb begin
    f.active = 1'b1;
    f.empty  = (level == '0);
    f.avail  = (level != '0);
    f.full   = (level == (AW+1)'(DEPTH));
    f.half   = dir_rx ? (level >= (AW+1)'(DEPTH/2)) : (level <= (AW+1)'(DEPTH/2));
  end

  always_comb begin
    stat = '0;
    stat[B_DATA_END]  = done;
    stat[B_BLOCK_END] = done;
    if (en) begin
      stat[B_ACT   + int'(dir_rx)] = f.active;
      stat[B_HALF  + int'(dir_rx)] = f.half;
      stat[B_FULL  + int'(dir_rx)] = f.full;
      stat[B_EMPTY + int'(dir_rx)] = f.empty;
      stat[B_AVAIL + int'(dir_rx)] = f.avail;
    end
  end
endmodule

// File: rtl/bwe_engine.sv
module bwe_engine
  import bwe_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              ctrl_enable,
  input  logic              ctrl_dir_rx,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic              host_wr,
  input  logic [W-1:0]      host_wdata,
  input  logic              host_rd,
  output logic              host_rvalid,
  output logic [W-1:0]      host_rdata,
  input  logic              card_rx_valid,
  input  logic [7:0]        card_rx_byte,
  output logic              card_rx_ready,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_byte,
  input  logic              card_tx_ready,
  output logic              data_en,
  output logic [LEN_W-1:0]  byte_count,
  output logic [STAT_W-1:0] status
);
  logic             en_q, dir_q, done_q, hpop_q, hok_q;
  logic [LEN_W-1:0] count_q;
  logic             load, cnt_nz, last_byte, rx_mode, tx_mode;
  logic             rx_take, rx_push, tx_send, tx_pop, tx_have, tx_busy;
  logic             host_push_ok, host_pop_ok, byte_move;
  logic             ring_full, ring_empty;
  logic [AW:0]      ring_level;
  logic [W-1:0]     ring_rdata, rx_word;

  assign load      = ctrl_wr & ctrl_enable;
  assign cnt_nz    = (count_q != '0);
  assign last_byte = (count_q == LEN_W'(1));
  assign rx_mode   = en_q & dir_q;
  assign tx_mode   = en_q & ~dir_q;

  assign card_rx_ready = rx_mode & cnt_nz & ~ring_full;
  assign rx_take       = card_rx_ready & card_rx_valid;
  assign card_tx_valid = tx_mode & cnt_nz & tx_have;
  assign tx_send       = card_tx_valid & card_tx_ready;
  assign byte_move     = rx_take | tx_send;

  assign host_push_ok = host_wr & tx_mode & cnt_nz & ~ring_full;
  assign host_pop_ok  = host_rd & dir_q & ~ring_empty;

  bwe_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .push  (rx_push | host_push_ok),
    .wdata (dir_q ? rx_word : host_wdata),
    .pop   (host_pop_ok | tx_pop),
    .rdata (ring_rdata),
    .level (ring_level),
    .full  (ring_full),
    .empty (ring_empty)
  );

  bwe_rx_pack #(.W(W)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .clear  (ctrl_wr),
    .take   (rx_take),
    .byte_i (card_rx_byte),
    .last   (last_byte),
    .push   (rx_push),
    .word   (rx_word)
  );

  bwe_tx_unpack #(.W(W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .clear      (ctrl_wr),
    .can_fetch  (tx_mode & cnt_nz & ~ring_empty),
    .fetch_data (ring_rdata),
    .send       (tx_send),
    .last       (last_byte),
    .pop_req    (tx_pop),
    .have       (tx_have),
    .busy       (tx_busy),
    .byte_o     (card_tx_byte)
  );

  bwe_status #(.DEPTH(DEPTH)) u_stat (
    .en     (en_q),
    .dir_rx (dir_q),
    .done   (done_q),
    .level  (ring_level),
    .stat   (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      count_q <= '0;
      hpop_q  <= 1'b0;
      hok_q   <= 1'b0;
    end else begin
      hpop_q <= host_rd;
      hok_q  <= host_pop_ok;
      if (load) begin
        count_q <= xfer_len;
        en_q    <= 1'b1;
        dir_q   <= ctrl_dir_rx;
        done_q  <= (xfer_len == '0);
      end else if (ctrl_wr) begin
        en_q  <= 1'b0;
        dir_q <= ctrl_dir_rx;
      end else begin
        if (byte_move) begin
          count_q <= count_q - LEN_W'(1);
          if (last_byte) done_q <= 1'b1;
        end
        if (en_q && !cnt_nz && ring_empty && !tx_busy) en_q <= 1'b0;
      end
    end
  end

  assign host_rvalid = hpop_q;
  assign host_rdata  = hok_q ? ring_rdata : '0;
  assign data_en     = en_q;
  assign byte_count  = count_q;
endmodule

// File: rtl/bwe_engine_chk.sv
module bwe_engine_chk
  import bwe_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_wr,
  input logic              en,
  input logic              dir_rx,
  input logic [LEN_W-1:0]  count,
  input logic [AW:0]       level,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_byte,
  input logic [STAT_W-1:0] status
);
  localparam logic [STAT_W-1:0] TX_GRP = STAT_W'(32'h0015_5000);
  localparam logic [STAT_W-1:0] RX_GRP = STAT_W'(32'h002A_A000);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));

  // R4
  rx_ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (dir_rx && count != '0 && level != (AW+1)'(DEPTH)));

  // R6
  tx_count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !ctrl_wr) |=> (count == $past(count) - LEN_W'(1)));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !ctrl_wr) |=> (tx_valid && $stable(tx_byte)));

  // R9
  group_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & (dir_rx ? TX_GRP : RX_GRP)) == '0) && (en || ((status & (TX_GRP | RX_GRP)) == '0)));

  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ctrl_wr && (count != '0 || level != '0)) |=> en);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (status[B_DATA_END] && !ctrl_wr) |=> (status[B_DATA_END] && status[B_BLOCK_END]));
endmodule

bind bwe_engine bwe_engine_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_bwe_chk (
  .clk      (clk),
  .rst      (rst),
  .ctrl_wr  (ctrl_wr),
  .en       (data_en),
  .dir_rx   (dir_q),
  .count    (byte_count),
  .level    (ring_level),
  .rx_ready (card_rx_ready),
  .tx_valid (card_tx_valid),
  .tx_ready (card_tx_ready),
  .tx_byte  (card_tx_byte),
  .status   (status)
);

// File: tb/tb_bwe_engine.sv
`timescale 1ns/1ps
module tb_bwe_engine;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctrl_wr, ctrl_enable, ctrl_dir_rx;
  logic [15:0] xfer_len;
  logic        host_wr, host_rd, host_rvalid;
  logic [31:0] host_wdata, host_rdata;
  logic        card_rx_valid, card_rx_ready;
  logic [7:0]  card_rx_byte, card_tx_byte;
  logic        card_tx_valid, card_tx_ready;
  logic        data_en;
  logic [15:0] byte_count;
  logic [21:0] status;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  bwe_engine dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_enable(ctrl_enable),
    .ctrl_dir_rx(ctrl_dir_rx), .xfer_len(xfer_len), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rvalid(host_rvalid),
    .host_rdata(host_rdata), .card_rx_valid(card_rx_valid),
    .card_rx_byte(card_rx_byte), .card_rx_ready(card_rx_ready),
    .card_tx_valid(card_tx_valid), .card_tx_byte(card_tx_byte),
    .card_tx_ready(card_tx_ready), .data_en(data_en),
    .byte_count(byte_count), .status(status)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] exp_stat(bit en, bit rx, int lvl, bit done);
    logic [21:0] s;
    int o;
    s = '0;
    o = rx ? 1 : 0;
    if (done) begin s[8] = 1'b1; s[10] = 1'b1; end
    if (en) begin
      s[12+o] = 1'b1;
      if (rx) begin if (lvl >= 8) s[15] = 1'b1; end
      else if (lvl <= 8) s[14] = 1'b1;
      if (lvl == 16) s[16+o] = 1'b1;
      if (lvl == 0) s[18+o] = 1'b1; else s[20+o] = 1'b1;
    end
    return s;
  endfunction

  function automatic logic [7:0] rxb(int k, int it);
    return (it < 0) ? 8'(k) : 8'(k*13 + it*5 + 1);
  endfunction

  function automatic logic [7:0] txb(int k, int it);
    return (it < 0) ? 8'(k) : 8'(k*11 + it*3 + 2);
  endfunction

  function automatic logic [31:0] rx_word(int j, int len, int it);
    logic [31:0] w;
    w = '0;
    for (int b = 0; b < 4; b++)
      if (4*j + b < len) w[8*b +: 8] = rxb(4*j + b, it);
    return w;
  endfunction

  function automatic logic [31:0] tx_word(int j, int it);
    return {txb(4*j+3, it), txb(4*j+2, it), txb(4*j+1, it), txb(4*j, it)};
  endfunction

  task automatic start(int len, bit rx);
    ctrl_wr = 1'b1; ctrl_enable = 1'b1; ctrl_dir_rx = rx; xfer_len = 16'(len);
    step();
    ctrl_wr = 1'b0; ctrl_enable = 1'b0;
  endtask

  task automatic host_push(logic [31:0] w);
    host_wr = 1'b1; host_wdata = w;
    step();
    host_wr = 1'b0;
    step();
  endtask

  task automatic host_pop(output logic v, output logic [31:0] d);
    host_rd = 1'b1;
    step();
    host_rd = 1'b0;
    v = host_rvalid; d = host_rdata;
  endtask

  task automatic rx_send(int first, int n);
    for (int i = first; i < first + n; i++) begin
      card_rx_valid = 1'b1; card_rx_byte = rxb(i, -1);
      while (!card_rx_ready) step();
      step();
    end
    card_rx_valid = 1'b0;
  endtask

  task automatic rx_run(int len, int it);
    int sent, got;
    sent = 0; got = 0;
    start(len, 1'b1);
    while (1) begin
      bit do_send, do_pop;
      do_send = 1'b0; do_pop = 1'b0;
      if (sent < len && ($urandom % 4) != 0) begin
        card_rx_valid = 1'b1; card_rx_byte = rxb(sent, it);
        do_send = card_rx_ready;
      end
      if (status[21] && ($urandom % 3) == 0) begin host_rd = 1'b1; do_pop = 1'b1; end
      step();
      card_rx_valid = 1'b0; host_rd = 1'b0;
      if (do_send) sent++;
      if (do_pop) begin
        // R4 R5: packed words, partial last word zero padded
        check((4*got + 4 > len) ? "R5 rx partial word" : "R4 rx word",
              host_rdata, rx_word(got, len, it));
        got++;
      end
      if (sent == len && !data_en) break;
    end
    check("R5 rx word total", 32'(got), 32'((len + 3) / 4));
  endtask

  task automatic tx_run(int len, int it, int first, int total);
    int pushed, rcv;
    bit was_stall;
    logic [7:0] held;
    pushed = first; rcv = 0; was_stall = 1'b0; held = '0;
    while (1) begin
      bit rdy, do_push;
      rdy = ($urandom % 3) != 0;
      do_push = (pushed < total) && status[14] && (($urandom % 2) == 0);
      if (was_stall && card_tx_valid) check("R10 tx byte held", 32'(card_tx_byte), 32'(held));
      was_stall = card_tx_valid && !rdy;
      held = card_tx_byte;
      if (card_tx_valid && rdy) begin
        check("R6 tx byte order", 32'(card_tx_byte), 32'(txb(rcv, it)));
        rcv++;
      end
      card_tx_ready = rdy;
      if (do_push) begin host_wr = 1'b1; host_wdata = tx_word(pushed, it); pushed++; end
      step();
      host_wr = 1'b0; card_tx_ready = 1'b0;
      if (rcv == len && !data_en) break;
    end
    check("R3 count at end", 32'(byte_count), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic v;
    logic [31:0] d;
    void'($urandom(32'd4242));
    rst = 1'b1; ctrl_wr = 0; ctrl_enable = 0; ctrl_dir_rx = 0; xfer_len = 0;
    host_wr = 0; host_wdata = 0; host_rd = 0; card_rx_valid = 0; card_rx_byte = 0;
    card_tx_ready = 0;
    repeat (4) step();
    rst = 1'b0;
    step();

    // reset state (R3, R9)
    check("R3 reset data_en", 32'(data_en), 0);
    check("R3 reset count", 32'(byte_count), 0);
    check("R9 reset status", 32'(status), 0);
    check("R4 reset rx_ready", 32'(card_rx_ready), 0);
    check("R6 reset tx_valid", 32'(card_tx_valid), 0);

    // R2: pop on empty store
    host_pop(v, d);
    check("R2 empty pop valid", 32'(v), 1);
    check("R2 empty pop data", d, 0);

    // R7 R8: zero-length start
    start(0, 1'b1);
    check("R7 zero length done bits", 32'(status & 22'h500), 32'h500);
    step(); step();
    check("R8 zero length en clears", 32'(data_en), 0);

    // R3 R4 R5: six bytes card to host
    start(6, 1'b1);
    check("R3 count loaded", 32'(byte_count), 6);
    rx_send(1, 3);
    check("R3 count after three", 32'(byte_count), 3);
    rx_send(4, 3);
    step(); step();
    check("R9 rx two words status", 32'(status), 32'(exp_stat(1, 1, 2, 1)));
    check("R8 en held with words", 32'(data_en), 1);
    host_pop(v, d);
    check("R4 rx first word", d, 32'h04030201);
    host_pop(v, d);
    check("R5 rx partial word", d, 32'h00000605);
    step(); step();
    check("R8 en clears when empty", 32'(data_en), 0);
    check("R9 groups clear when idle", 32'(status), 32'h500);

    // R4 R1: fill store from card, host push ignored in this direction
    start(80, 1'b1);
    rx_send(0, 64);
    step(); step();
    check("R4 rx ready low when full", 32'(card_rx_ready), 0);
    check("R9 rx full status", 32'(status), 32'(exp_stat(1, 1, 16, 0)));
    host_push(32'hDEADBEEF);
    for (int j = 0; j < 16; j++) begin
      host_pop(v, d);
      check("R4 rx full word", d, rx_word(j, 64, -1));
    end
    rx_send(64, 16);
    step(); step();
    for (int j = 16; j < 20; j++) begin
      host_pop(v, d);
      check("R4 rx tail word", d, {8'(4*j+3), 8'(4*j+2), 8'(4*j+1), 8'(4*j)});
    end
    host_pop(v, d);
    check("R1 rx push dropped", d, 0);
    check("R2 rx empty pop valid", 32'(v), 1);
    step(); step();
    check("R8 rx full run ends", 32'(data_en), 0);

    // R1 R2 R6 R9: host to card, store filled while card stalls
    start(68, 1'b0);
    for (int j = 0; j < 9; j++) host_push(tx_word(j, -1));
    step(); step();
    check("R9 tx level eight status", 32'(status), 32'(exp_stat(1, 0, 8, 0)));
    check("R6 tx first byte offered", 32'(card_tx_valid), 1);
    check("R6 tx first byte value", 32'(card_tx_byte), 0);
    host_pop(v, d);
    check("R2 pop in tx direction data", d, 0);
    check("R2 pop in tx direction valid", 32'(v), 1);
    for (int j = 9; j < 18; j++) host_push(tx_word(j, -1));
    step(); step();
    check("R1 tx store full status", 32'(status), 32'(exp_stat(1, 0, 16, 0)));
    tx_run(68, -1, 18, 18);
    step(); step();
    check("R1 extra push dropped en low", 32'(data_en), 0);
    check("R7 tx done status", 32'(status), 32'h500);

    // random runs in both directions
    for (int it = 0; it < 6; it++) begin
      int len;
      len = 1 + int'($urandom % 40);
      rx_run(len, it);
      step();
      len = 1 + int'($urandom % 40);
      start(len, 1'b0);
      tx_run(len, it, 0, (len + 3) / 4);
      step();
      check("R8 random tx ends idle", 32'(data_en), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule